// File: doc/BRIEF.md
# Macroblock Coefficient Dequantizer and Block Sequencer

This block sits between an entropy decoder and an inverse-transform engine. It takes a stream of 16-bit coefficient words. Each word carries a 6-bit zero-run count in bits [15:10] and a 10-bit two's-complement coefficient in bits [9:0]. The block rescales each coefficient by a quantizer value taken from an external table, and writes the result into a 64-entry coefficient store. When a block is complete, it hands that store to the transform. A macroblock holds six blocks, visited in a fixed order: red-difference chroma, blue-difference chroma, then four luma blocks.

The first word of each block is the DC term. It always lands at position 0, and its run field is not used. Each later word advances the write position by its run count plus one. A later word whose run field is all ones (63) closes the block. The block then pulses a start strobe towards the transform, stalls its input, and waits for two things: a fixed cycle budget must run out, and the transform must report done. After that it clears the store, moves to the next block index, and signals when chroma-plus-luma colour output may proceed.

Top module: `mb_dequant_seq`

## Requirements
- R1: After reset, `inReady`=1, `blkIdx`=0, `lumaBlk`=0, `xfStart`=0, `colorGo`=0, `budgetCnt`=0, and every store entry reads 0.
- R2: The first word of a block is stored at position 0. While it is offered, `tblAddr`=0. With q=`tblQ` nonzero, the stored value is ci*q*16 minus 8 for ci>0, plus 8 for ci<0, and unchanged for ci=0.
- R3: A later word with run field r (r<63) targets position p+r+1, where p is the previous position, and `tblAddr` shows that position. With q nonzero, the stored value is (ci*q arithmetically shifted right by 3)*16, with the same ±8 correction toward zero as R2.
- R4: When q=0, on either path, the stored value is ci*32 with no correction.
- R5: Stored values saturate to the range -32768..32767.
- R6: A non-first word with run field 63 ends the block. During the next cycle `xfStart` is high for exactly one cycle, with `budgetCnt`=BUDGET-1.
- R7: A word whose target position exceeds 63 is dropped. Every later word of that block is dropped too, and the entries already written are left unchanged.
- R8: After an end word, `inReady` stays low until both of these hold: `budgetCnt` has counted down to 0 (at least BUDGET cycles), and `xfDone` has been seen. No input word is taken during that time.
- R9: `blkIdx` goes 0,1,2,3,4,5,0… with one step per completed block. `lumaBlk` is 1 exactly when `blkIdx`≥2.
- R10: `colorGo` pulses for one cycle when a block with index ≥2 completes, and never pulses for index 0 or 1.
- R11: When a block completes, every store entry returns to 0. Positions never written in a block read 0.
- R12: While nonzero, `budgetCnt` falls by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Coefficient word offered |
| inWord | input | 16 | Run count [15:10], coefficient [9:0] |
| inReady | output | 1 | Word taken when high together with inValid |
| tblAddr | output | 6 | Quantizer-table position for the offered word |
| tblQ | input | 8 | Quantizer value for `tblAddr`, unsigned, same cycle |
| xfStart | output | 1 | One-cycle request to transform the store |
| xfDone | input | 1 | Transform finished (pulse or level) |
| rdAddr | input | 6 | Store read position for the transform |
| rdData | output | 16 | Store contents at `rdAddr`, signed |
| blkIdx | output | 3 | Block being filled (0 Cr, 1 Cb, 2..5 Y) |
| lumaBlk | output | 1 | Current block targets the luma buffer |
| colorGo | output | 1 | Luma block completed; colour output may run |
| budgetCnt | output | 10 | Remaining budget cycles of the current transform |

## Verification
Suppose the write position or the DC/AC flag is wrong. Then `tblAddr` is wrong for the offered word in that same cycle, and the store read port shows a misplaced value at the very next sweep of `rdAddr`. A wrong sequencer state shows up in the first cycle after an end word: through `inReady`, `xfStart` or `budgetCnt`. A wrong block counter shows on `blkIdx` and `colorGo` in the cycle after completion. The bench sweeps the read address once every 64 cycles, so a corrupted store entry is seen within that many cycles.

// File: rtl/mb_dequant_seq_pkg.sv
package mb_dequant_seq_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic isDc;   // offered word is the first of its block
    logic wr;     // take the offered word as a coefficient
    logic clr;    // block completed: wipe store, rewind position
  } dqStrobe_t;

  typedef enum logic {ST_ACCEPT, ST_BUSY} seqState_t;
endpackage

// File: rtl/mb_dequant_dp.sv
module mb_dequant_dp
  import mb_dequant_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int COEF_W = 10,
  parameter int Q_W    = 8,
  parameter int OUT_W  = 16,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dqStrobe_t         strb,
  input  logic [WORD_W-1:0] inWord,
  output logic [$clog2(DEPTH)-1:0] tblAddr,
  input  logic [Q_W-1:0]    tblQ,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic [OUT_W-1:0]  rdData
);
  localparam int AW    = $clog2(DEPTH);
  localparam int RUN_W = WORD_W - COEF_W;
  localparam logic signed [31:0] MAX_V = 32'sd2 ** (OUT_W - 1) - 1;
  localparam logic signed [31:0] MIN_V = -(32'sd2 ** (OUT_W - 1));

  logic [AW:0]        pos;        // value DEPTH marks an overrun block
  logic [AW+1:0]      nextPos;
  logic               nextFits;
  logic [RUN_W-1:0]   runField;
  logic signed [31:0] ci, qS, prod, scaled, corr, raw;
  logic [OUT_W-1:0]   dqVal;
  logic [OUT_W-1:0]   coefMem [DEPTH];

  assign runField = inWord[WORD_W-1:COEF_W];
  assign nextPos  = (AW+2)'(pos) + (AW+2)'(runField) + (AW+2)'(1);
  assign nextFits = nextPos < (AW+2)'(DEPTH);
  assign tblAddr  = strb.isDc ? '0 : nextPos[AW-1:0];

  always_comb begin
    ci     = {{(32-COEF_W){inWord[COEF_W-1]}}, inWord[COEF_W-1:0]};
    qS     = {{(32-Q_W){1'b0}}, tblQ};
    prod   = ci * qS;
    scaled = strb.isDc ? prod : (prod >>> 3);
    if (ci > 0)      corr = -32'sd8;
    else if (ci < 0) corr = 32'sd8;
    else             corr = '0;
    if (tblQ == '0) raw = ci <<< 5;
    else            raw = (scaled <<< 4) + corr;
    if (raw > MAX_V)      dqVal = MAX_V[OUT_W-1:0];
    else if (raw < MIN_V) dqVal = MIN_V[OUT_W-1:0];
    else                  dqVal = raw[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos <= '0;
      for (int i = 0; i < DEPTH; i++) coefMem[i] <= '0;
    end else if (strb.clr) begin
      pos <= '0;
      for (int i = 0; i < DEPTH; i++) coefMem[i] <= '0;
    end else if (strb.wr) begin
      if (strb.isDc) begin
        pos        <= '0;
        coefMem[0] <= dqVal;
      end else if (nextFits) begin
        pos                     <= nextPos[AW:0];
        coefMem[nextPos[AW-1:0]] <= dqVal;
      end else begin
        pos <= (AW+1)'(DEPTH);
      end
    end
  end

  assign rdData = coefMem[rdAddr];
endmodule

// File: rtl/mb_dequant_ctl.sv
module mb_dequant_ctl
  import mb_dequant_seq_pkg::*;
#(
  parameter int RUN_W      = 6,
  parameter int BUDGET     = 512,
  parameter int NUM_BLK    = 6,
  parameter int LUMA_FIRST = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [RUN_W-1:0] runField,
  output logic             inReady,
  output logic             xfStart,
  input  logic             xfDone,
  output dqStrobe_t        strb,
  output logic [$clog2(NUM_BLK)-1:0] blkIdx,
  output logic             lumaBlk,
  output logic             colorGo,
  output logic [$clog2(BUDGET+1)-1:0] budgetCnt
);
  localparam int BW = $clog2(BUDGET + 1);
  localparam int IW = $clog2(NUM_BLK);

  seqState_t state;
  logic      expectDc, doneSeen, accept, endWord, finish;

  assign inReady = (state == ST_ACCEPT);
  assign accept  = inValid && inReady;
  assign endWord = accept && !expectDc && (runField == '1);
  assign finish  = (state == ST_BUSY) && (budgetCnt == '0) && (doneSeen || xfDone);
  assign lumaBlk = blkIdx >= IW'(LUMA_FIRST);

  assign strb.isDc = expectDc;
  assign strb.wr   = accept && !endWord;
  assign strb.clr  = finish;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_ACCEPT;
      expectDc  <= 1'b1;
      doneSeen  <= 1'b0;
      xfStart   <= 1'b0;
      colorGo   <= 1'b0;
      blkIdx    <= '0;
      budgetCnt <= '0;
    end else begin
      xfStart <= 1'b0;
      colorGo <= 1'b0;
      if (state == ST_ACCEPT) begin
        if (endWord) begin
          state     <= ST_BUSY;
          xfStart   <= 1'b1;
          budgetCnt <= BW'(BUDGET - 1);
          doneSeen  <= 1'b0;
        end else if (accept && expectDc) begin
          expectDc <= 1'b0;
        end
      end else if (finish) begin
        state    <= ST_ACCEPT;
        expectDc <= 1'b1;
        doneSeen <= 1'b0;
        colorGo  <= lumaBlk;
        blkIdx   <= (blkIdx == IW'(NUM_BLK - 1)) ? '0 : blkIdx + 1'b1;
      end else begin
        if (budgetCnt != '0) budgetCnt <= budgetCnt - 1'b1;
        if (xfDone) doneSeen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mb_dequant_seq.sv
module mb_dequant_seq
  import mb_dequant_seq_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int COEF_W     = 10,
  parameter int Q_W        = 8,
  parameter int OUT_W      = 16,
  parameter int DEPTH      = 64,
  parameter int BUDGET     = 512,
  parameter int NUM_BLK    = 6,
  parameter int LUMA_FIRST = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [WORD_W-1:0]     inWord,
  output logic                  inReady,
  output logic [$clog2(DEPTH)-1:0] tblAddr,
  input  logic [Q_W-1:0]        tblQ,
  output logic                  xfStart,
  input  logic                  xfDone,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic [OUT_W-1:0]      rdData,
  output logic [$clog2(NUM_BLK)-1:0] blkIdx,
  output logic                  lumaBlk,
  output logic                  colorGo,
  output logic [$clog2(BUDGET+1)-1:0] budgetCnt
);
  localparam int RUN_W = WORD_W - COEF_W;

  dqStrobe_t strb;

  mb_dequant_ctl #(
    .RUN_W(RUN_W), .BUDGET(BUDGET), .NUM_BLK(NUM_BLK), .LUMA_FIRST(LUMA_FIRST)
  ) uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .runField(inWord[WORD_W-1:COEF_W]), .inReady(inReady),
    .xfStart(xfStart), .xfDone(xfDone), .strb(strb),
    .blkIdx(blkIdx), .lumaBlk(lumaBlk), .colorGo(colorGo), .budgetCnt(budgetCnt)
  );

  mb_dequant_dp #(
    .WORD_W(WORD_W), .COEF_W(COEF_W), .Q_W(Q_W), .OUT_W(OUT_W), .DEPTH(DEPTH)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .inWord(inWord),
    .tblAddr(tblAddr), .tblQ(tblQ), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/mb_dequant_seq_chk.sv
module mb_dequant_seq_chk #(
  parameter int BUDGET     = 512,
  parameter int NUM_BLK    = 6,
  parameter int LUMA_FIRST = 2
) (
  input logic clk,
  input logic rstN,
  input logic inReady,
  input logic xfStart,
  input logic [$clog2(NUM_BLK)-1:0] blkIdx,
  input logic lumaBlk,
  input logic colorGo,
  input logic [$clog2(BUDGET+1)-1:0] budgetCnt
);
  localparam int BW = $clog2(BUDGET + 1);
  localparam int IW = $clog2(NUM_BLK);

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    xfStart |=> !xfStart);
  // R6
  start_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    xfStart |-> (budgetCnt == BW'(BUDGET - 1)) && !inReady);
  // R8
  stall_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    (budgetCnt != '0) |-> !inReady);
  // R12
  budget_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (budgetCnt != '0) |=> (budgetCnt == $past(budgetCnt) - 1'b1));
  // R9
  blk_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkIdx < IW'(NUM_BLK));
  // R9
  blk_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blkIdx != $past(blkIdx)) |->
      (blkIdx == (($past(blkIdx) == IW'(NUM_BLK - 1)) ? '0 : $past(blkIdx) + 1'b1)));
  // R10
  color_luma_chk: assert property (@(posedge clk) disable iff (!rstN)
    colorGo |-> ($past(blkIdx) >= IW'(LUMA_FIRST)));
  // R10
  color_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    colorGo |=> !colorGo);
endmodule

bind mb_dequant_seq mb_dequant_seq_chk #(
  .BUDGET(BUDGET), .NUM_BLK(NUM_BLK), .LUMA_FIRST(LUMA_FIRST)
) uChk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .xfStart(xfStart),
  .blkIdx(blkIdx), .lumaBlk(lumaBlk), .colorGo(colorGo), .budgetCnt(budgetCnt)
);

// File: tb/mb_dequant_seq_test.sv
`timescale 1ns/1ps
module mb_dequant_seq_test;
  localparam int BUDGET = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inWord = '0;
  logic        inReady;
  logic [5:0]  tblAddr;
  logic [7:0]  tblQ;
  logic        xfStart;
  logic        xfDone = 1'b0;
  logic [5:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic [2:0]  blkIdx;
  logic        lumaBlk;
  logic        colorGo;
  logic [9:0]  budgetCnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int qMode = 0;
  int respDelay = 20;
  bit finished = 0;

  always #4 clk = ~clk;

  mb_dequant_seq #(.BUDGET(BUDGET)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord), .inReady(inReady),
    .tblAddr(tblAddr), .tblQ(tblQ), .xfStart(xfStart), .xfDone(xfDone),
    .rdAddr(rdAddr), .rdData(rdData), .blkIdx(blkIdx), .lumaBlk(lumaBlk),
    .colorGo(colorGo), .budgetCnt(budgetCnt)
  );

  // quantizer table provided by the bench; some entries are zero (R4)
  function automatic int qf(int mode, int a);
    if (mode == 2 && a == 0) return 0;
    if (a % 5 == 2) return 0;
    return (a * 29 + mode * 50 + 11) & 255;
  endfunction

  always_comb tblQ = 8'(qf(qMode, int'(tblAddr)));

  // rescaling rule from R2..R5
  function automatic int deq(int ci, int q, bit dc);
    int p, r;
    if (q == 0) r = ci * 32;
    else begin
      p = ci * q;
      if (!dc) p = p >>> 3;
      r = p * 16;
      if (ci > 0) r -= 8;
      else if (ci < 0) r += 8;
    end
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference model
  int mem [64];
  int mPos, mBud, mBlk;
  bit mBusy, mExpDc, mSeen, mXf, mCol;

  always @(posedge clk) begin
    int run, ci, np;
    if (!rstN) begin
      foreach (mem[i]) mem[i] = 0;
      mPos = 0; mBud = 0; mBlk = 0;
      mBusy = 0; mExpDc = 1; mSeen = 0; mXf = 0; mCol = 0;
    end else begin
      mXf = 0; mCol = 0;
      if (!mBusy) begin
        if (inValid) begin
          run = int'(inWord[15:10]);
          ci  = $signed(inWord[9:0]);
          if (!mExpDc && run == 63) begin
            mBusy = 1; mXf = 1; mBud = BUDGET - 1; mSeen = 0;
          end else if (mExpDc) begin
            mem[0] = deq(ci, qf(qMode, 0), 1); mPos = 0; mExpDc = 0;
          end else begin
            np = mPos + run + 1;
            if (np <= 63) mem[np] = deq(ci, qf(qMode, np), 0);
            mPos = (np > 63) ? 64 : np;
          end
        end
      end else if (mBud == 0 && (mSeen || xfDone)) begin
        foreach (mem[i]) mem[i] = 0;
        mCol = (mBlk >= 2);
        mBlk = (mBlk == 5) ? 0 : mBlk + 1;
        mExpDc = 1; mBusy = 0; mPos = 0;
      end else begin
        if (mBud > 0) mBud--;
        if (xfDone) mSeen = 1;
      end
    end
  end

  // per-cycle comparison, away from the edges
  always @(negedge clk) begin
    #1;
    cycles++;
    if (rstN && !finished) begin
      int run, np;
      chk("R8 inReady", int'(inReady), int'(!mBusy));
      chk("R6 xfStart", int'(xfStart), int'(mXf));
      chk("R9 blkIdx", int'(blkIdx), mBlk);
      chk("R9 lumaBlk", int'(lumaBlk), int'(mBlk >= 2));
      chk("R10 colorGo", int'(colorGo), int'(mCol));
      chk("R12 budgetCnt", int'(budgetCnt), mBud);
      // store contents: R2 R3 R4 R5 R7 R11
      chk("R11 rdData", int'($signed(rdData)), mem[rdAddr]);
      if (!mBusy && inValid) begin
        run = int'(inWord[15:10]);
        if (mExpDc) chk("R2 tblAddr", int'(tblAddr), 0);
        else if (run != 63) begin
          np = mPos + run + 1;
          if (np <= 63) chk("R3 tblAddr", int'(tblAddr), np);
        end
      end
      rdAddr = rdAddr + 6'd1;
    end
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // transform responder
  initial begin
    forever begin
      @(negedge clk);
      if (xfStart) begin
        repeat (respDelay) @(negedge clk);
        xfDone = 1'b1;
        @(negedge clk);
        xfDone = 1'b0;
      end
    end
  end

  function automatic logic [15:0] mk(int run, int ci);
    return {6'(run), 10'(ci)};
  endfunction

  task automatic send(logic [15:0] w);
    inValid = 1'b1; inWord = w;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 inReady", int'(inReady), 1);
    chk("R1 blkIdx", int'(blkIdx), 0);
    chk("R1 lumaBlk", int'(lumaBlk), 0);
    chk("R1 xfStart", int'(xfStart), 0);
    chk("R1 colorGo", int'(colorGo), 0);
    chk("R1 budgetCnt", int'(budgetCnt), 0);
    chk("R1 rdData", int'(rdData), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int mb = 0; mb < 2; mb++) begin
      for (int b = 0; b < 6; b++) begin
        qMode = (b + mb) % 3;
        respDelay = (b == 3 && mb == 0) ? 600 : 20 + b;   // late done exercises R8
        // DC word (R2, R4 when qMode 2, R5 saturation for large ci)
        if (b == 1 && mb == 0) send(mk(5, 511));
        else send(mk(b + 7, ((b * 97 + mb * 31) % 1023) - 511));
        if (b == 4) begin
          // R7 overrun: 41 fits, 72 dropped, everything after dropped
          send(mk(40, 77));
          send(mk(30, -66));
          send(mk(0, 12));
        end else begin
          for (int k = 0; k < 5; k++) begin
            send(mk((b + k * 3) % 5, ((k * 53 + b * 19 + mb * 7) % 41) - 20));
            if (k == 2) repeat (b % 3) @(negedge clk);
          end
          if (b == 2) send(mk(1, -512));   // R5 negative saturation
          if (b == 5) send(mk(0, 0));      // zero coefficient
        end
        send(mk(63, b));                   // R6 end word
      end
    end
    repeat (700) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule